// File: doc/BRIEF.md
# Zero-Crossing Locked Milestone Sequencer

This block produces the per-half-cycle command pattern for a staircase-shaped input-current reference in a boost power-factor stage. A free-running counter advances by one on every tick strobe (1 µs nominal). The block stamps the rising and falling edges of a hysteretic mains comparator pulse with that counter. From these stamps it derives a time base: the pulse centre, moved back by a fixed shift that undoes the comparator skew.

After a lead-in delay measured from that base, the block walks a built-in table of interval lengths. Each time the counter reaches the next boundary, it issues one action code. The codes in order are: choose the low current level, force the inhibit line, choose the low level again, choose the high level, and finally re-arm the zero-crossing detector. The real current magnitudes are supplied elsewhere. This block only drives the level select, the inhibit line and a busy flag.

An enable command arms the block. The sequence then starts at the next comparator pulse. A disable command stops everything at once.

Top module: `zc_milestone_seq`

## Requirements
- R1: After reset the block is disabled, `lvl_hi` is 0, `inhibit` is 0 and `busy` is 0.
- R2: While disabled, comparator pulses have no effect. After `en_cmd`, nothing happens until the next rising edge of `zc_in`.
- R3: When armed, a rising edge of `zc_in` stores the tick count and sets `busy` in the same clock, so `busy` reads 1 from the next clock on.
- R4: With rise stamp `r` and fall stamp `f` (len = f - r, in ticks), the lead-in milestone lands at `r + floor(len/2) - CTR_SHIFT + MS_OFFSET` (defaults 20 and 820). All arithmetic is modulo 2^16.
- R5: After the lead-in milestone, the next boundaries follow at gaps of 411, 382, 411, 5500 and 5000 ticks. An output changes in the clock whose tick edge moves the counter past the boundary value.
- R6: The actions at those five boundaries are, in order:
  - LOW: `lvl_hi`=0, `inhibit`=0.
  - INHIBIT: `inhibit`=1, `lvl_hi` kept.
  - LOW.
  - HIGH: `lvl_hi`=1, `inhibit`=0.
  - REARM: `busy`=0, the level is kept.
- R7: Edges on `zc_in` while `busy` is 1 are ignored and do not move any later boundary.
- R8: After REARM, the next rising edge of `zc_in` starts a fresh sequence with the same timing.
- R9: `dis_cmd` forces `busy`, `inhibit` and `lvl_hi` to 0 on the next clock. Later pulses are then ignored until `en_cmd`.
- R10: The tick counter advances only on clocks where `tick` is 1. All timing above is counted in ticks, not clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock time-base strobe |
| zc_in | input | 1 | Zero-crossing comparator pulse, synchronous to clk |
| en_cmd | input | 1 | Arm the sequencer (one-clock pulse) |
| dis_cmd | input | 1 | Stop at once (one-clock pulse, wins over enable) |
| lvl_hi | output | 1 | Current-level select: 1 high, 0 low |
| inhibit | output | 1 | Inhibit line to the switch modulator |
| busy | output | 1 | Sequence in progress |

## Verification
Every action is timed from a single stored boundary value, so a wrong stamp, a wrong halving or a wrong table entry moves every later edge of `inhibit`, `lvl_hi` and `busy` by the same number of ticks. Such an error shows up at the very next visible transition. A broken action index reorders or drops the level and inhibit transitions within one half-cycle. A leak in the ignore or disable logic shows up as a `busy` edge that no accepted pulse explains. Each edge is therefore compared against the tick count at which it is due, not only against its value.

// File: rtl/zc_milestone_seq.sv
module zc_milestone_seq #(
  parameter int TW        = 16,
  parameter int MS_OFFSET = 820,
  parameter int CTR_SHIFT = 20,
  parameter int IV0       = 411,
  parameter int IV1       = 382,
  parameter int IV2       = 411,
  parameter int IV3       = 5500,
  parameter int IV4       = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic zc_in,
  input  logic en_cmd,
  input  logic dis_cmd,
  output logic lvl_hi,
  output logic inhibit,
  output logic busy
);

  localparam int PW = 3;
  localparam logic [2:0] A_END   = 3'd0;
  localparam logic [2:0] A_LOW   = 3'd1;
  localparam logic [2:0] A_INH   = 3'd2;
  localparam logic [2:0] A_HIGH  = 3'd3;
  localparam logic [2:0] A_REARM = 3'd4;
  localparam logic [PW-1:0] LAST = PW'(5);

  typedef enum logic [1:0] {S_OFF, S_ARM, S_PULSE, S_RUN} st_t;

  function automatic logic [TW-1:0] ivl(input logic [PW-1:0] i);
    case (i)
      3'd0:    ivl = TW'(IV0);
      3'd1:    ivl = TW'(IV1);
      3'd2:    ivl = TW'(IV2);
      3'd3:    ivl = TW'(IV3);
      3'd4:    ivl = TW'(IV4);
      default: ivl = '0;
    endcase
  endfunction

  function automatic logic [2:0] act(input logic [PW-1:0] i);
    case (i)
      3'd0:    act = A_LOW;
      3'd1:    act = A_INH;
      3'd2:    act = A_LOW;
      3'd3:    act = A_HIGH;
      3'd4:    act = A_REARM;
      default: act = A_END;
    endcase
  endfunction

  st_t           st;
  logic          zc_q;
  logic [TW-1:0] tcnt, rise_ts, tgt, plen, first_tgt, nxt_ivl;
  logic [PW-1:0] pos;
  logic [2:0]    cur_act;

  wire zc_rise = zc_in & ~zc_q;
  wire zc_fall = ~zc_in & zc_q;
  wire match   = tick && (st == S_RUN) && (tcnt == tgt);

  assign plen      = tcnt - rise_ts;
  assign first_tgt = rise_ts + (plen >> 1) - TW'(CTR_SHIFT) + TW'(MS_OFFSET);
  assign cur_act   = act(pos - PW'(1));
  assign nxt_ivl   = ivl(pos);
  assign busy      = (st == S_PULSE) || (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      zc_q    <= 1'b0;
      tcnt    <= '0;
      rise_ts <= '0;
      tgt     <= '0;
      pos     <= '0;
      lvl_hi  <= 1'b0;
      inhibit <= 1'b0;
    end else begin
      zc_q <= zc_in;
      if (tick) tcnt <= tcnt + TW'(1);
      if (dis_cmd) begin
        st      <= S_OFF;
        lvl_hi  <= 1'b0;
        inhibit <= 1'b0;
      end else begin
        case (st)
          S_OFF:   if (en_cmd) st <= S_ARM;
          S_ARM:   if (zc_rise) begin
                     rise_ts <= tcnt;
                     st      <= S_PULSE;
                   end
          S_PULSE: if (zc_fall) begin
                     tgt <= first_tgt;
                     pos <= '0;
                     st  <= S_RUN;
                   end
          S_RUN:   if (match) begin
                     if (pos == '0) begin
                       tgt <= tgt + ivl(pos);
                       pos <= PW'(1);
                     end else begin
                       case (cur_act)
                         A_LOW:   begin lvl_hi <= 1'b0; inhibit <= 1'b0; end
                         A_INH:   inhibit <= 1'b1;
                         A_HIGH:  begin lvl_hi <= 1'b1; inhibit <= 1'b0; end
                         default: ;
                       endcase
                       if (cur_act == A_REARM || cur_act == A_END || nxt_ivl == '0)
                         st <= S_ARM;
                       else begin
                         tgt <= tgt + nxt_ivl;
                         pos <= pos + PW'(1);
                       end
                     end
                   end
          default: st <= S_OFF;
        endcase
      end
    end
  end

  // R6
  inh_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> busy);

  // R9
  dis_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> (!busy && !inhibit && !lvl_hi));

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !match) |=> $stable(tgt));

  // R2
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(zc_in && !zc_q));

  // R5
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> (pos <= LAST));

  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tcnt));

endmodule

// File: tb/tb_zc_milestone_seq.sv
module tb_zc_milestone_seq;
  localparam int OFF   = 820;
  localparam int SHIFT = 20;

  logic clk = 0, rst_n = 0, tick = 0, zc_in = 0, en_cmd = 0, dis_cmd = 0;
  logic lvl_hi, inhibit, busy;

  always #10 clk = ~clk;

  zc_milestone_seq dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .zc_in(zc_in),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .lvl_hi(lvl_hi), .inhibit(inhibit), .busy(busy)
  );

  logic [15:0] bt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bt <= '0;
    else if (tick) bt <= bt + 16'd1;

  always @(negedge clk) tick <= ~tick;

  typedef struct {
    logic [2:0]  v;
    logic [15:0] t;
    string       r;
  } ev_t;
  ev_t q[$];

  int n_tests = 0, n_fail = 0;
  bit mon_on = 0;
  logic [2:0] prev, ev;

  // scoreboard monitor: {lvl_hi, inhibit, busy}
  always @(negedge clk) begin
    if (mon_on) begin
      logic [2:0] cur;
      ev_t e;
      cur = {lvl_hi, inhibit, busy};
      if (cur !== prev) begin
        n_tests++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 or R7: unexpected change to %b at tick %0d, expected no change", cur, bt);
        end else begin
          e = q.pop_front();
          if (e.v !== cur || e.t !== bt) begin
            n_fail++;
            $display("FAIL %s: got %b at tick %0d, expected %b at tick %0d", e.r, cur, bt, e.v, e.t);
          end
        end
        prev = cur;
      end
    end
  end

  task automatic push(input logic [2:0] v, input logic [15:0] t, input string r);
    ev_t e;
    if (v != ev) begin
      e.v = v; e.t = t; e.r = r;
      q.push_back(e);
    end
    ev = v;
  endtask

  task automatic quiet();
    do begin @(negedge clk); #1; end while (tick !== 1'b0);
  endtask

  task automatic wait_bt(input logic [15:0] v);
    do quiet(); while (bt !== v);
  endtask

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string r);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b, expected %b", r, act, exp);
    end
  endtask

  task automatic pulse_cmd(input bit dis);
    quiet();
    if (dis) dis_cmd = 1; else en_cmd = 1;
    @(posedge clk); #1;
    dis_cmd = 0; en_cmd = 0;
  endtask

  task automatic run_seq(input int len, input int n_act, input bit inject);
    logic [15:0] r, m;
    quiet();
    zc_in = 1;
    r = bt;
    push({ev[2], ev[1], 1'b1}, r, "R3");
    wait_bt(r + 16'(len));
    zc_in = 0;
    m = r + 16'(len / 2) - 16'(SHIFT) + 16'(OFF);
    m += 16'd411;  push({2'b00, 1'b1}, m + 16'd1, "R4");
    if (n_act >= 2) begin m += 16'd382;  push({ev[2], 2'b11}, m + 16'd1, "R6"); end
    if (n_act >= 3) begin m += 16'd411;  push(3'b001, m + 16'd1, "R6"); end
    if (n_act >= 4) begin m += 16'd5500; push(3'b101, m + 16'd1, "R5"); end
    if (n_act >= 5) begin m += 16'd5000; push({ev[2], 2'b00}, m + 16'd1, "R8"); end
    if (inject) begin
      // R7: extra comparator pulse during the run
      wait_bt(r + 16'(len) + 16'd200);
      zc_in = 1;
      wait_bt(r + 16'(len) + 16'd230);
      zc_in = 0;
    end
    wait_bt(m + 16'd2);
  endtask

  task automatic main();
    repeat (4) @(posedge clk);
    quiet();
    rst_n = 1;
    // R1
    chk({lvl_hi, inhibit, busy}, 3'b000, "R1");
    prev = 3'b000; ev = 3'b000; mon_on = 1;

    // R2: pulse while disabled
    quiet(); zc_in = 1;
    wait_bt(bt + 16'd20); zc_in = 0;
    wait_bt(bt + 16'd50);
    chk({lvl_hi, inhibit, busy}, 3'b000, "R2");

    pulse_cmd(0);
    wait_bt(bt + 16'd30);
    chk({lvl_hi, inhibit, busy}, 3'b000, "R2");

    run_seq(40, 5, 0);
    wait_bt(bt + 16'd100);
    run_seq(57, 5, 1);
    wait_bt(bt + 16'd50);

    // R9: stop right after the inhibit action
    run_seq(10, 2, 0);
    quiet();
    dis_cmd = 1;
    push(3'b000, bt, "R9");
    @(posedge clk); #1; dis_cmd = 0;
    wait_bt(bt + 16'd5);
    chk({lvl_hi, inhibit, busy}, 3'b000, "R9");
    quiet(); zc_in = 1;
    wait_bt(bt + 16'd15); zc_in = 0;
    wait_bt(bt + 16'd900);
    chk({lvl_hi, inhibit, busy}, 3'b000, "R9");

    pulse_cmd(0);
    wait_bt(bt + 16'd10);
    run_seq(24, 5, 0);

    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R6: %0d scheduled transitions missing, expected 0", q.size());
    end
  endtask

  initial begin
    fork
      main();
      begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R8: watchdog expired at tick %0d, expected sequence end", bt);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule